// File: doc/BRIEF.md
# Delegated Interrupt Pending Selector

This block decides, every cycle, whether a hart must take an interrupt and which line it takes. It holds the pending vector, which is updated through a masked write port. Each pending line is qualified by its enable bit. Whether a candidate line may actually fire depends on where the line is routed by the delegation mask and on the hart's current privilege level together with the matching global enable bit.

Among all lines that may fire, the lowest-numbered one wins. The decision comes out as a take flag and a 5-bit cause number, optionally through one output register. A separate request line tells the core that at least one pending bit is set, without regard to enables or privilege.

Privilege is a 2-bit code: 0 is user, 1 is supervisor, 3 is machine. Code 2 is not a defined level and is handled as described in R8.

Top module: `intr_pick`

## Requirements
- R1: When `pend_wr_en` is high at a rising clock edge, the pending vector becomes `(old & ~pend_wr_mask) | (pend_wr_data & pend_wr_mask)`. `pend_now` shows the old value up to that edge and the new value after it. With `pend_wr_en` low, the pending vector holds its value.
- R2: `irq_line` is high exactly when at least one bit of `pend_now` is set.
- R3: A line whose `deleg_vec` bit is 0 is eligible when its pending and enable bits are both set and either the privilege code is below 3 (machine), or it is 3 and `m_gie` is 1.
- R4: A line whose `deleg_vec` bit is 1 is eligible when its pending and enable bits are both set and either the privilege is 0 (user), or it is 1 (supervisor) and `s_gie` is 1. At privilege 3, a delegated line is never eligible.
- R5: When several lines are eligible, `irq_cause` is the index of the lowest-numbered eligible line and `take_irq` is 1.
- R6: When no line is eligible, `take_irq` is 0 and `irq_cause` is 0.
- R7: With `REG_OUT=1` (the default), `take_irq` and `irq_cause` change one clock edge after the inputs and the pending vector they depend on. Reset clears the pending vector, `take_irq` and `irq_cause`.
- R8: Privilege code 2 is treated as below machine and above supervisor. Non-delegated lines are eligible regardless of `m_gie`, and delegated lines are never eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_wr_en | input | 1 | Apply a masked write to the pending vector |
| pend_wr_mask | input | NUM_IRQ | Bits of the pending vector to replace |
| pend_wr_data | input | NUM_IRQ | New values for the masked bits |
| pend_now | output | NUM_IRQ | Current pending vector (old value during a write cycle) |
| irq_line | output | 1 | Any pending bit set |
| enable_vec | input | NUM_IRQ | Per-line enable |
| deleg_vec | input | NUM_IRQ | 1 routes the line to supervisor level |
| cur_priv | input | 2 | Current privilege code (0 user, 1 supervisor, 3 machine) |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| take_irq | output | 1 | An interrupt should be taken |
| irq_cause | output | 5 | Index of the selected line |

## Verification
The assertions assume that reset is applied before any write and that `NUM_IRQ` does not exceed 32, so every line index fits the 5-bit cause. They also assume the inputs are stable around the clock edge. The stimulus respects this by changing every input on the falling edge. It sweeps all four privilege codes and both global enables over random pending, enable and delegation masks, and checks each result against a bench model written from R3 to R8. A table of directed vectors covers the delegated, non-delegated and reserved-privilege corners.

// File: rtl/intr_pick_pkg.sv
package intr_pick_pkg;

    typedef enum logic [1:0] {
        PRIV_USR  = 2'd0,
        PRIV_SUP  = 2'd1,
        PRIV_RSV  = 2'd2,
        PRIV_MACH = 2'd3
    } priv_t;

    localparam int CAUSE_W = 5;

endpackage

// File: rtl/intr_pend_reg.sv
module intr_pend_reg #(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NUM_IRQ-1:0] wr_mask,
    input  logic [NUM_IRQ-1:0] wr_data,
    output logic [NUM_IRQ-1:0] pend_q,
    output logic               any_pend
);

    logic [NUM_IRQ-1:0] pend_d;

    always_comb begin
        pend_d = pend_q;
        if (wr_en) begin
            pend_d = (pend_q & ~wr_mask) | (wr_data & wr_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign any_pend = |pend_q;

    // R1
    pend_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pend_q == $past((pend_q & ~wr_mask) | (wr_data & wr_mask)));

    // R1
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pend_q));

endmodule

// File: rtl/intr_elig.sv
module intr_elig
    import intr_pick_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0] pend,
    input  logic [NUM_IRQ-1:0] enable,
    input  logic [NUM_IRQ-1:0] deleg,
    input  priv_t              priv,
    input  logic               m_gie,
    input  logic               s_gie,
    output logic [NUM_IRQ-1:0] elig
);

    logic               mach_open;
    logic               sup_open;
    logic [NUM_IRQ-1:0] cand;

    always_comb begin
        cand      = pend & enable;
        mach_open = (priv != PRIV_MACH) || m_gie;
        sup_open  = (priv == PRIV_USR) || ((priv == PRIV_SUP) && s_gie);
        elig      = (cand & ~deleg & {NUM_IRQ{mach_open}})
                  | (cand &  deleg & {NUM_IRQ{sup_open}});
    end

    always_comb begin
        // R4
        if (priv == PRIV_MACH) begin
            mach_no_deleg_chk: assert ((elig & deleg) == '0);
        end
        // R3
        elig_subset_chk: assert ((elig & ~(pend & enable)) == '0);
    end

endmodule

// File: rtl/intr_prio.sv
module intr_prio
    import intr_pick_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0] elig,
    output logic               found,
    output logic [CAUSE_W-1:0] cause
);

    always_comb begin
        found = 1'b0;
        cause = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                cause = CAUSE_W'(i);
            end
        end
    end

    always_comb begin
        // R5
        if (found) begin
            win_bit_chk: assert (elig[cause]);
        end
        // R5
        for (int j = 0; j < NUM_IRQ; j++) begin
            if (found && (j < int'(cause))) begin
                lowest_win_chk: assert (!elig[j]);
            end
        end
        // R6
        none_quiet_chk: assert ((elig != '0) || (!found && cause == '0));
    end

endmodule

// File: rtl/intr_pick.sv
module intr_pick
    import intr_pick_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pend_wr_en,
    input  logic [NUM_IRQ-1:0] pend_wr_mask,
    input  logic [NUM_IRQ-1:0] pend_wr_data,
    output logic [NUM_IRQ-1:0] pend_now,
    output logic               irq_line,
    input  logic [NUM_IRQ-1:0] enable_vec,
    input  logic [NUM_IRQ-1:0] deleg_vec,
    input  logic [1:0]         cur_priv,
    input  logic               m_gie,
    input  logic               s_gie,
    output logic               take_irq,
    output logic [4:0]         irq_cause
);

    logic [NUM_IRQ-1:0] elig;
    logic               found;
    logic [CAUSE_W-1:0] cause;

    intr_pend_reg #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (pend_wr_en),
        .wr_mask  (pend_wr_mask),
        .wr_data  (pend_wr_data),
        .pend_q   (pend_now),
        .any_pend (irq_line)
    );

    intr_elig #(.NUM_IRQ(NUM_IRQ)) u_elig (
        .pend   (pend_now),
        .enable (enable_vec),
        .deleg  (deleg_vec),
        .priv   (priv_t'(cur_priv)),
        .m_gie  (m_gie),
        .s_gie  (s_gie),
        .elig   (elig)
    );

    intr_prio #(.NUM_IRQ(NUM_IRQ)) u_prio (
        .elig  (elig),
        .found (found),
        .cause (cause)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    take_irq  <= 1'b0;
                    irq_cause <= '0;
                end else begin
                    take_irq  <= found;
                    irq_cause <= cause;
                end
            end

            // R2
            take_has_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
                take_irq |-> $past(irq_line));
        end else begin : g_comb
            assign take_irq  = found;
            assign irq_cause = cause;

            // R2
            take_has_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
                take_irq |-> irq_line);
        end
    endgenerate

endmodule

// File: tb/intr_pick_bench.sv
`timescale 1ns/1ps
module intr_pick_bench;

    localparam int N = 32;

    typedef struct packed {
        logic [31:0] pend;
        logic [31:0] en;
        logic [31:0] dg;
        logic [1:0]  pv;
        logic        mg;
        logic        sg;
        logic        tk;
        logic [4:0]  cs;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0088, 32'hFFFF_FFFF, 32'h0000_0000, 2'd3, 1'b1, 1'b0, 1'b1, 5'd3},
        '{32'h0000_0088, 32'hFFFF_FFFF, 32'h0000_0000, 2'd3, 1'b0, 1'b0, 1'b0, 5'd0},
        '{32'h0000_0022, 32'hFFFF_FFFF, 32'h0000_0022, 2'd3, 1'b1, 1'b1, 1'b0, 5'd0},
        '{32'h0000_0022, 32'hFFFF_FFFF, 32'h0000_0022, 2'd1, 1'b0, 1'b1, 1'b1, 5'd1},
        '{32'h0000_0022, 32'hFFFF_FFFF, 32'h0000_0022, 2'd1, 1'b1, 1'b0, 1'b0, 5'd0},
        '{32'h0000_0022, 32'hFFFF_FFFF, 32'h0000_0022, 2'd0, 1'b0, 1'b0, 1'b1, 5'd1},
        '{32'h0000_0A00, 32'h0000_0800, 32'h0000_0000, 2'd1, 1'b0, 1'b0, 1'b1, 5'd11},
        '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 2'd2, 1'b0, 1'b0, 1'b1, 5'd31},
        '{32'h0000_0202, 32'hFFFF_FFFF, 32'h0000_0002, 2'd2, 1'b0, 1'b1, 1'b1, 5'd9},
        '{32'h0000_0202, 32'hFFFF_FFFF, 32'h0000_0200, 2'd1, 1'b0, 1'b0, 1'b1, 5'd1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pend_wr_en = 1'b0;
    logic [N-1:0] pend_wr_mask = '0;
    logic [N-1:0] pend_wr_data = '0;
    logic [N-1:0] pend_now;
    logic         irq_line;
    logic [N-1:0] enable_vec = '0;
    logic [N-1:0] deleg_vec = '0;
    logic [1:0]   cur_priv = 2'd3;
    logic         m_gie = 1'b0;
    logic         s_gie = 1'b0;
    logic         take_irq;
    logic [4:0]   irq_cause;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    intr_pick u_intr_pick (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend_wr_en   (pend_wr_en),
        .pend_wr_mask (pend_wr_mask),
        .pend_wr_data (pend_wr_data),
        .pend_now     (pend_now),
        .irq_line     (irq_line),
        .enable_vec   (enable_vec),
        .deleg_vec    (deleg_vec),
        .cur_priv     (cur_priv),
        .m_gie        (m_gie),
        .s_gie        (s_gie),
        .take_irq     (take_irq),
        .irq_cause    (irq_cause)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Bench model built from R3, R4, R5, R6, R8
    function automatic logic [5:0] ref_pick(input logic [31:0] p, input logic [31:0] e,
                                            input logic [31:0] d, input logic [1:0] pv,
                                            input logic mg, input logic sg);
        logic mach_ok;
        logic sup_ok;
        mach_ok = (pv == 2'd0) || (pv == 2'd1) || (pv == 2'd2) || mg;
        sup_ok  = (pv == 2'd0) || ((pv == 2'd1) && sg);
        for (int b = 0; b < 32; b++) begin
            if (p[b] && e[b] && ((d[b] && sup_ok) || (!d[b] && mach_ok))) begin
                return {1'b1, 5'(b)};
            end
        end
        return 6'd0;
    endfunction

    // Load pending with a full write, set the rest, and let the output register capture
    task automatic apply(input logic [31:0] p, input logic [31:0] e, input logic [31:0] d,
                         input logic [1:0] pv, input logic mg, input logic sg);
        @(negedge clk);
        pend_wr_en   = 1'b1;
        pend_wr_mask = '1;
        pend_wr_data = p;
        enable_vec   = e;
        deleg_vec    = d;
        cur_priv     = pv;
        m_gie        = mg;
        s_gie        = sg;
        @(negedge clk);
        pend_wr_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [5:0]  expv;
        logic [31:0] old_v;
        repeat (3) @(negedge clk);
        // R7 reset state
        chk("R7 reset take", 32'(take_irq), 32'd0);
        chk("R7 reset cause", 32'(irq_cause), 32'd0);
        chk("R7 reset pend", pend_now, 32'd0);
        chk("R2 reset line", 32'(irq_line), 32'd0);
        rst_n = 1'b1;

        // Directed table: R3 R4 R5 R6 R8
        for (int k = 0; k < NVEC; k++) begin
            apply(VECS[k].pend, VECS[k].en, VECS[k].dg, VECS[k].pv, VECS[k].mg, VECS[k].sg);
            chk($sformatf("R5 table take %0d", k), 32'(take_irq), 32'(VECS[k].tk));
            chk($sformatf("R6 table cause %0d", k), 32'(irq_cause), 32'(VECS[k].cs));
            chk($sformatf("R2 table line %0d", k), 32'(irq_line), 32'(VECS[k].pend != 0));
        end

        // R1 masked write, old value visible until the edge
        apply(32'hF0F0_00FF, 32'h0, 32'h0, 2'd3, 1'b0, 1'b0);
        @(negedge clk);
        pend_wr_en   = 1'b1;
        pend_wr_mask = 32'h0000_FF0F;
        pend_wr_data = 32'h1234_5670;
        #1;
        old_v = pend_now;
        chk("R1 old value before edge", old_v, 32'hF0F0_00FF);
        @(negedge clk);
        pend_wr_en = 1'b0;
        chk("R1 merged value", pend_now, 32'hF0F0_56F0);
        @(negedge clk);
        chk("R1 hold without write", pend_now, 32'hF0F0_56F0);

        // R2 clearing all pending drops the line
        @(negedge clk);
        pend_wr_en   = 1'b1;
        pend_wr_mask = '1;
        pend_wr_data = '0;
        @(negedge clk);
        pend_wr_en = 1'b0;
        chk("R2 line low when empty", 32'(irq_line), 32'd0);

        // R7 one-edge lag of the decision
        apply(32'h0000_0008, 32'hFFFF_FFFF, 32'h0, 2'd3, 1'b1, 1'b0);
        chk("R7 take before change", 32'(take_irq), 32'd1);
        @(negedge clk);
        m_gie = 1'b0;
        #1;
        chk("R7 take holds until edge", 32'(take_irq), 32'd1);
        @(negedge clk);
        chk("R7 take drops after edge", 32'(take_irq), 32'd0);

        // Sweep: every privilege and enable combination with random masks
        for (int pv = 0; pv < 4; pv++) begin
            for (int g = 0; g < 4; g++) begin
                for (int r = 0; r < 20; r++) begin
                    logic [31:0] p;
                    logic [31:0] e;
                    logic [31:0] d;
                    p = $urandom() & $urandom();
                    e = $urandom();
                    d = $urandom();
                    apply(p, e, d, 2'(pv), g[0], g[1]);
                    expv = ref_pick(p, e, d, 2'(pv), g[0], g[1]);
                    chk($sformatf("R3 R4 sweep take pv%0d", pv), 32'(take_irq), 32'(expv[5]));
                    chk($sformatf("R5 sweep cause pv%0d", pv), 32'(irq_cause), 32'(expv[4:0]));
                end
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule